// File: doc/BRIEF.md
# Tiled Surface Address Generator

This block turns a two-dimensional element position on a graphics surface into the byte address of that element in memory. A request carries the surface base address, a byte offset and a row offset that place a sub-resource inside the surface, the surface pitch, the element size, a layout code and the element coordinate. The block returns one registered byte address per result, together with a flag that marks the last result of a request and a flag that marks a rejected request.

Three layouts are supported. The first is a plain pitch-linear layout. The second is a tiled layout in which the surface is cut into 4 KiB tiles, each 128 bytes wide and 32 rows tall. The tiles are stored row after row, and the row and column bits inside a tile are interleaved. The third is the same tiled layout with one extra address bit folded in. A request can also ask for a raster walk over a rectangle. In that case the block produces the address of every element, row by row, at up to one element per cycle, and the caller needs to send only one request.

Top module: `tile_addr_gen`

## Requirements
- R1: With `in_mode` = 2'b00 (linear), the address is base + (yoff + y) * pitch + xoff + (x << esz), taken modulo 2^ADDR_W.
- R2: With `in_mode` = 2'b01 (tiled), let XB = xoff + (x << esz) and YR = yoff + y. The address is base + (YR >> 5) * pitch + (XB >> 7) * 4096 + T, modulo 2^ADDR_W. T is a 12-bit in-tile offset with bits [3:0] = XB[3:0], bits [8:4] = YR[4:0] and bits [11:9] = XB[6:4].
- R3: With `in_mode` = 2'b10 (tiled, folded), the address is first computed as in R2, including the base. Bit 6 of that full sum is then replaced by the XOR of its bit 6 and its bit 9.
- R4: With `in_mode` = 2'b11, or with an `in_esz` code above 4, the result carries `out_err` = 1 and `out_addr` = 0.
- R5: `in_esz` is the base-2 logarithm of the element size in bytes. Codes 0 to 4 select sizes of 1, 2, 4, 8 and 16 bytes.
- R6: A result that is not stalled is valid on the outputs after the second rising edge, counting the edge that accepts the request (or issues the walk element) as the first.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_addr`, `out_last` and `out_err` hold their values.
- R8: With `in_walk` = 1, the block ignores `in_x` and `in_y`. It issues elements for x = 0..w-1 within y = 0..h-1, in row-major order, and sets `out_last` only on the final element. A width or height of 0 counts as 1. A request with `in_walk` = 0 gives one result with `out_last` = 1.
- R9: After the block accepts a walk of more than one element, `in_ready` stays 0 until it has issued the final element.
- R10: During reset and directly after it, `out_valid` is 0. With the pipeline empty, `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted on this edge when in_valid is 1 |
| in_base | input | ADDR_W | Surface base byte address |
| in_xoff | input | XOFF_W | Sub-resource byte offset along a row |
| in_yoff | input | YOFF_W | Sub-resource row offset |
| in_pitch | input | PITCH_W | Bytes per row (linear) or per row of tiles (tiled) |
| in_esz | input | 3 | log2 of the element size in bytes |
| in_mode | input | 2 | Layout code: 00 linear, 01 tiled, 10 tiled folded, 11 reserved |
| in_x | input | COORD_W | Element column (single request) |
| in_y | input | COORD_W | Element row (single request) |
| in_walk | input | 1 | 1 requests a raster walk over in_w by in_h elements |
| in_w | input | COORD_W | Walk width in elements |
| in_h | input | COORD_W | Walk height in elements |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_addr | output | ADDR_W | Computed byte address |
| out_last | output | 1 | Final result of the request |
| out_err | output | 1 | Request rejected (reserved layout or element size) |

## Verification
Random requests mix all four layout codes and every element-size code, with random offsets, pitches and coordinates. This separates a wrong bit interleave, a wrong tile stride and a folded bit-6 error from a plain linear miscount. Directed requests choose offsets whose bit 9 is set, so that only the folded layout gives a different answer. Small walks, including walks with zero width or height, are mixed with random backpressure on `out_ready`, which shows errors in the walk order, in the placement of the last flag and in the holding of stalled results. Single directed requests measure the pipeline latency and the blocking of `in_ready` during a walk.

// File: rtl/tag_pkg.sv
package tag_pkg;
   typedef enum logic [1:0] {
      MD_LINEAR    = 2'b00,
      MD_TILED     = 2'b01,
      MD_TILED_FLD = 2'b10,
      MD_RSVD      = 2'b11
   } tag_mode_e;

   // tile geometry: 128 bytes by 32 rows, 4096 bytes per tile
   localparam int TILE_W_LOG2 = 7;
   localparam int TILE_H_LOG2 = 5;
   localparam int TILE_B_LOG2 = TILE_W_LOG2 + TILE_H_LOG2;
   localparam int ESZ_MAX     = 4;
   localparam int ESZ_W       = 3;
endpackage

// File: rtl/tag_walker.sv
module tag_walker #(
   parameter int ADDR_W  = 32,
   parameter int COORD_W = 12,
   parameter int XOFF_W  = 16,
   parameter int YOFF_W  = 14,
   parameter int PITCH_W = 18
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [ADDR_W-1:0]  in_base,
   input  logic [XOFF_W-1:0]  in_xoff,
   input  logic [YOFF_W-1:0]  in_yoff,
   input  logic [PITCH_W-1:0] in_pitch,
   input  logic [2:0]         in_esz,
   input  logic [1:0]         in_mode,
   input  logic [COORD_W-1:0] in_x,
   input  logic [COORD_W-1:0] in_y,
   input  logic               in_walk,
   input  logic [COORD_W-1:0] in_w,
   input  logic [COORD_W-1:0] in_h,
   input  logic               take,
   output logic               f_valid,
   output logic [ADDR_W-1:0]  f_base,
   output logic [XOFF_W-1:0]  f_xoff,
   output logic [YOFF_W-1:0]  f_yoff,
   output logic [PITCH_W-1:0] f_pitch,
   output logic [2:0]         f_esz,
   output logic [1:0]         f_mode,
   output logic [COORD_W-1:0] f_x,
   output logic [COORD_W-1:0] f_y,
   output logic               f_last
);
   logic               busy;
   logic [ADDR_W-1:0]  h_base;
   logic [XOFF_W-1:0]  h_xoff;
   logic [YOFF_W-1:0]  h_yoff;
   logic [PITCH_W-1:0] h_pitch;
   logic [2:0]         h_esz;
   logic [1:0]         h_mode;
   logic [COORD_W-1:0] h_w, h_h, cx, cy;
   logic [COORD_W-1:0] w_sel, h_sel;
   logic               walk_sel, x_end, y_end, fire;

   always_comb begin
      f_base   = busy ? h_base  : in_base;
      f_xoff   = busy ? h_xoff  : in_xoff;
      f_yoff   = busy ? h_yoff  : in_yoff;
      f_pitch  = busy ? h_pitch : in_pitch;
      f_esz    = busy ? h_esz   : in_esz;
      f_mode   = busy ? h_mode  : in_mode;
      w_sel    = busy ? h_w     : in_w;
      h_sel    = busy ? h_h     : in_h;
      walk_sel = busy | in_walk;
      f_x      = busy ? cx : (in_walk ? '0 : in_x);
      f_y      = busy ? cy : (in_walk ? '0 : in_y);
      // a zero extent behaves like one: x+1 >= 0 always holds
      x_end    = ({1'b0, f_x} + 1'b1) >= {1'b0, w_sel};
      y_end    = ({1'b0, f_y} + 1'b1) >= {1'b0, h_sel};
      f_last   = !walk_sel || (x_end && y_end);
      f_valid  = busy | in_valid;
      fire     = f_valid & take;
      in_ready = !busy & take;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         cx      <= '0;
         cy      <= '0;
         h_base  <= '0;
         h_xoff  <= '0;
         h_yoff  <= '0;
         h_pitch <= '0;
         h_esz   <= '0;
         h_mode  <= '0;
         h_w     <= '0;
         h_h     <= '0;
      end else if (fire) begin
         if (f_last) begin
            busy <= 1'b0;
         end else begin
            busy <= 1'b1;
            cx   <= x_end ? '0 : f_x + COORD_W'(1);
            cy   <= x_end ? f_y + COORD_W'(1) : f_y;
            if (!busy) begin
               h_base  <= in_base;
               h_xoff  <= in_xoff;
               h_yoff  <= in_yoff;
               h_pitch <= in_pitch;
               h_esz   <= in_esz;
               h_mode  <= in_mode;
               h_w     <= in_w;
               h_h     <= in_h;
            end
         end
      end
   end
endmodule

// File: rtl/tag_split.sv
module tag_split
   import tag_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int COORD_W = 12,
   parameter int XOFF_W  = 16,
   parameter int YOFF_W  = 14,
   parameter int PITCH_W = 18,
   parameter int XB_W    = 17,
   parameter int YR_W    = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               i_valid,
   input  logic [ADDR_W-1:0]  i_base,
   input  logic [XOFF_W-1:0]  i_xoff,
   input  logic [YOFF_W-1:0]  i_yoff,
   input  logic [PITCH_W-1:0] i_pitch,
   input  logic [2:0]         i_esz,
   input  logic [1:0]         i_mode,
   input  logic [COORD_W-1:0] i_x,
   input  logic [COORD_W-1:0] i_y,
   input  logic               i_last,
   input  logic               adv,
   output logic               o_take,
   output logic               o_valid,
   output logic [ADDR_W-1:0]  o_base,
   output logic [ADDR_W-1:0]  o_row,
   output logic [ADDR_W-1:0]  o_col,
   output logic               o_fold,
   output logic               o_err,
   output logic               o_last
);
   localparam int TC_W = XB_W - TILE_W_LOG2;

   logic [XB_W-1:0]        xb;
   logic [YR_W-1:0]        yr, row_idx;
   logic [TILE_B_LOG2-1:0] ofs;
   logic                   tiled, err;
   logic [ADDR_W-1:0]      row_b, col_b;

   assign xb = XB_W'(i_xoff) + (XB_W'(i_x) << i_esz);
   assign yr = YR_W'(i_yoff) + YR_W'(i_y);

   // in-tile offset: x[3:0] low, then five row bits, then x[6:4]
   for (genvar b = 0; b < TILE_B_LOG2; b++) begin : g_ofs
      if (b < 4) begin : g_xl
         assign ofs[b] = xb[b];
      end else if (b < 4 + TILE_H_LOG2) begin : g_yr
         assign ofs[b] = yr[b-4];
      end else begin : g_xh
         assign ofs[b] = xb[b-TILE_H_LOG2];
      end
   end

   always_comb begin
      tiled   = (i_mode == MD_TILED) || (i_mode == MD_TILED_FLD);
      err     = (i_mode == MD_RSVD) || (i_esz > 3'(ESZ_MAX));
      row_idx = tiled ? (yr >> TILE_H_LOG2) : yr;
      row_b   = ADDR_W'(row_idx) * ADDR_W'(i_pitch);
      col_b   = tiled ? ADDR_W'({xb[XB_W-1:TILE_W_LOG2], ofs}) : ADDR_W'(xb);
   end

   assign o_take = !o_valid || adv;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_valid <= 1'b0;
         o_base  <= '0;
         o_row   <= '0;
         o_col   <= '0;
         o_fold  <= 1'b0;
         o_err   <= 1'b0;
         o_last  <= 1'b0;
      end else if (o_take) begin
         o_valid <= i_valid;
         if (i_valid) begin
            o_base <= i_base;
            o_row  <= row_b;
            o_col  <= col_b;
            o_fold <= (i_mode == MD_TILED_FLD);
            o_err  <= err;
            o_last <= i_last;
         end
      end
   end

   if (TC_W < 1) begin : g_bad_tc
      $error("tag_split: XB_W too narrow for a tile column");
   end
endmodule

// File: rtl/tag_merge.sv
module tag_merge #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              i_valid,
   input  logic [ADDR_W-1:0] i_base,
   input  logic [ADDR_W-1:0] i_row,
   input  logic [ADDR_W-1:0] i_col,
   input  logic              i_fold,
   input  logic              i_err,
   input  logic              i_last,
   input  logic              out_ready,
   output logic              o_adv,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr,
   output logic              out_last,
   output logic              out_err
);
   logic [ADDR_W-1:0] sum, fin;

   always_comb begin
      sum = i_base + i_row + i_col;
      fin = sum;
      if (i_fold) fin[6] = sum[6] ^ sum[9];
      if (i_err)  fin = '0;
   end

   assign o_adv = !out_valid || out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_addr  <= '0;
         out_last  <= 1'b0;
         out_err   <= 1'b0;
      end else if (o_adv) begin
         out_valid <= i_valid;
         if (i_valid) begin
            out_addr <= fin;
            out_last <= i_last;
            out_err  <= i_err;
         end
      end
   end
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen #(
   parameter int ADDR_W  = 32,
   parameter int COORD_W = 12,
   parameter int XOFF_W  = 16,
   parameter int YOFF_W  = 14,
   parameter int PITCH_W = 18
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [ADDR_W-1:0]  in_base,
   input  logic [XOFF_W-1:0]  in_xoff,
   input  logic [YOFF_W-1:0]  in_yoff,
   input  logic [PITCH_W-1:0] in_pitch,
   input  logic [2:0]         in_esz,
   input  logic [1:0]         in_mode,
   input  logic [COORD_W-1:0] in_x,
   input  logic [COORD_W-1:0] in_y,
   input  logic               in_walk,
   input  logic [COORD_W-1:0] in_w,
   input  logic [COORD_W-1:0] in_h,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [ADDR_W-1:0]  out_addr,
   output logic               out_last,
   output logic               out_err
);
   localparam int XB_W = ((XOFF_W > COORD_W + 4) ? XOFF_W : COORD_W + 4) + 1;
   localparam int YR_W = ((YOFF_W > COORD_W) ? YOFF_W : COORD_W) + 1;

   if (ADDR_W < 16) begin : g_bad_aw
      $error("tile_addr_gen: ADDR_W below 16");
   end
   if (XOFF_W < 7 || YOFF_W < 5) begin : g_bad_off
      $error("tile_addr_gen: offsets narrower than one tile");
   end
   if (YR_W > ADDR_W || PITCH_W > ADDR_W || XB_W + 5 > ADDR_W) begin : g_bad_fit
      $error("tile_addr_gen: address too narrow for its terms");
   end

   logic               f_valid, f_last, take, adv;
   logic [ADDR_W-1:0]  f_base;
   logic [XOFF_W-1:0]  f_xoff;
   logic [YOFF_W-1:0]  f_yoff;
   logic [PITCH_W-1:0] f_pitch;
   logic [2:0]         f_esz;
   logic [1:0]         f_mode;
   logic [COORD_W-1:0] f_x, f_y;
   logic               s_valid, s_fold, s_err, s_last;
   logic [ADDR_W-1:0]  s_base, s_row, s_col;

   tag_walker #(
      .ADDR_W(ADDR_W), .COORD_W(COORD_W), .XOFF_W(XOFF_W),
      .YOFF_W(YOFF_W), .PITCH_W(PITCH_W)
   ) u_walk (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_base(in_base), .in_xoff(in_xoff), .in_yoff(in_yoff),
      .in_pitch(in_pitch), .in_esz(in_esz), .in_mode(in_mode),
      .in_x(in_x), .in_y(in_y), .in_walk(in_walk), .in_w(in_w), .in_h(in_h),
      .take(take), .f_valid(f_valid),
      .f_base(f_base), .f_xoff(f_xoff), .f_yoff(f_yoff), .f_pitch(f_pitch),
      .f_esz(f_esz), .f_mode(f_mode), .f_x(f_x), .f_y(f_y), .f_last(f_last)
   );

   tag_split #(
      .ADDR_W(ADDR_W), .COORD_W(COORD_W), .XOFF_W(XOFF_W),
      .YOFF_W(YOFF_W), .PITCH_W(PITCH_W), .XB_W(XB_W), .YR_W(YR_W)
   ) u_split (
      .clk(clk), .rst_n(rst_n),
      .i_valid(f_valid), .i_base(f_base), .i_xoff(f_xoff), .i_yoff(f_yoff),
      .i_pitch(f_pitch), .i_esz(f_esz), .i_mode(f_mode),
      .i_x(f_x), .i_y(f_y), .i_last(f_last),
      .adv(adv), .o_take(take), .o_valid(s_valid),
      .o_base(s_base), .o_row(s_row), .o_col(s_col),
      .o_fold(s_fold), .o_err(s_err), .o_last(s_last)
   );

   tag_merge #(.ADDR_W(ADDR_W)) u_merge (
      .clk(clk), .rst_n(rst_n),
      .i_valid(s_valid), .i_base(s_base), .i_row(s_row), .i_col(s_col),
      .i_fold(s_fold), .i_err(s_err), .i_last(s_last),
      .out_ready(out_ready), .o_adv(adv),
      .out_valid(out_valid), .out_addr(out_addr),
      .out_last(out_last), .out_err(out_err)
   );
endmodule

// File: rtl/tile_addr_gen_chk.sv
module tile_addr_gen_chk #(
   parameter int ADDR_W  = 32,
   parameter int COORD_W = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               in_ready,
   input logic               in_walk,
   input logic [COORD_W-1:0] in_w,
   input logic [COORD_W-1:0] in_h,
   input logic               out_valid,
   input logic               out_ready,
   input logic [ADDR_W-1:0]  out_addr,
   input logic               out_last,
   input logic               out_err
);
   logic [1:0] age;

   always_ff @(posedge clk) begin
      if (!rst_n)          age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && $past(in_valid && in_ready, 2) && $past(out_ready, 1)) |-> out_valid);

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_addr) && $stable(out_last) && $stable(out_err)));

   p_err_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_err) |-> (out_addr == '0));

   p_walk_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_walk && (in_w > 1 || in_h > 1)) |=> !in_ready);
endmodule

bind tile_addr_gen tile_addr_gen_chk #(.ADDR_W(ADDR_W), .COORD_W(COORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_walk(in_walk), .in_w(in_w), .in_h(in_h),
   .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
   .out_last(out_last), .out_err(out_err)
);

// File: tb/tile_addr_gen_tb.sv
module tile_addr_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_base = '0;
   logic [15:0] in_xoff = '0;
   logic [13:0] in_yoff = '0;
   logic [17:0] in_pitch = '0;
   logic [2:0]  in_esz = '0;
   logic [1:0]  in_mode = '0;
   logic [11:0] in_x = '0, in_y = '0;
   logic        in_walk = 1'b0;
   logic [11:0] in_w = '0, in_h = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_addr;
   logic        out_last, out_err;

   int checks = 0;
   int errors = 0;
   bit bp_en = 1'b0;
   bit done = 1'b0;
   logic [33:0] expq[$];
   string       tagq[$];

   always #2.5 clk = ~clk;

   tile_addr_gen u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_base(in_base), .in_xoff(in_xoff), .in_yoff(in_yoff),
      .in_pitch(in_pitch), .in_esz(in_esz), .in_mode(in_mode),
      .in_x(in_x), .in_y(in_y), .in_walk(in_walk), .in_w(in_w), .in_h(in_h),
      .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
      .out_last(out_last), .out_err(out_err)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model(input logic [31:0] b, input logic [15:0] xo,
                                         input logic [13:0] yo, input logic [17:0] p,
                                         input int esz, input int md, input int x, input int y);
      longint xb, yr, a, off;
      xb = longint'(xo) + (longint'(x) << esz);
      yr = longint'(yo) + longint'(y);
      if (md == 0) begin
         a = longint'(b) + yr * longint'(p) + xb;
      end else begin
         off = (xb & 15) | ((xb & 'h70) << 5) | ((yr & 31) << 4);
         a = longint'(b) + (yr >> 5) * longint'(p) + (xb >> 7) * 4096 + off;
      end
      a = a & 64'hFFFF_FFFF;
      if (md == 2) a[6] = a[6] ^ a[9];
      return a[31:0];
   endfunction

   task automatic push(input logic [31:0] b, input logic [15:0] xo, input logic [13:0] yo,
                       input logic [17:0] p, input int esz, input int md,
                       input int x, input int y, input bit last, input string tag);
      logic [31:0] a;
      bit er;
      er = (md == 3) || (esz > 4);
      a  = er ? 32'h0 : model(b, xo, yo, p, esz, md, x, y);
      expq.push_back({er, last, a});
      tagq.push_back(er ? "R4" : tag);
   endtask

   task automatic send(input logic [31:0] b, input logic [15:0] xo, input logic [13:0] yo,
                       input logic [17:0] p, input int esz, input int md,
                       input int x, input int y, input bit walk, input int w, input int h,
                       input string tag);
      int ww, hh;
      @(negedge clk);
      in_base = b; in_xoff = xo; in_yoff = yo; in_pitch = p;
      in_esz = 3'(esz); in_mode = 2'(md); in_x = 12'(x); in_y = 12'(y);
      in_walk = walk; in_w = 12'(w); in_h = 12'(h); in_valid = 1'b1;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      if (walk) begin
         ww = (w == 0) ? 1 : w;
         hh = (h == 0) ? 1 : h;
         for (int yy = 0; yy < hh; yy++)
            for (int xx = 0; xx < ww; xx++)
               push(b, xo, yo, p, esz, md, xx, yy, (xx == ww-1) && (yy == hh-1), "R8");
      end else begin
         push(b, xo, yo, p, esz, md, x, y, 1'b1, tag);
      end
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   // backpressure on the result side
   initial begin
      forever begin
         @(negedge clk);
         out_ready = bp_en ? (($urandom % 4) != 0) : 1'b1;
      end
   end

   // result monitor, sampled well after the edge
   initial begin
      logic [33:0] e, held;
      bit stalled;
      string t;
      stalled = 1'b0;
      held = '0;
      forever begin
         @(negedge clk);
         #2;
         if (rst_n) begin
            if (stalled)
               chk(out_valid && ({out_err, out_last, out_addr} == held), "R7",
                   {out_err, out_last, out_addr}, held);
            stalled = out_valid && !out_ready;
            held = {out_err, out_last, out_addr};
            if (out_valid && out_ready) begin
               if (expq.size() == 0) begin
                  chk(1'b0, "R6 unexpected result", {out_err, out_last, out_addr}, 0);
               end else begin
                  e = expq.pop_front();
                  t = tagq.pop_front();
                  chk({out_err, out_last, out_addr} == e, t, {out_err, out_last, out_addr}, e);
               end
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R6 watchdog actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(posedge clk);
      #1;
      chk(out_valid == 1'b0, "R10 out_valid in reset", out_valid, 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
      chk(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);

      // R6: latency with the output free
      send(32'h1000, 16'h0, 14'h0, 18'd256, 0, 0, 5, 3, 1'b0, 0, 0, "R1");
      chk(out_valid == 1'b0, "R6 valid after first edge", out_valid, 0);
      @(posedge clk);
      #1;
      chk(out_valid == 1'b1, "R6 valid after second edge", out_valid, 1);
      repeat (3) @(posedge clk);

      // R9: walk blocks new requests until its final element
      send(32'h0, 16'h0, 14'h0, 18'd1024, 2, 1, 0, 0, 1'b1, 3, 2, "R8");
      @(negedge clk);
      #1;
      chk(in_ready == 1'b0, "R9 ready low during walk", in_ready, 0);
      repeat (5) @(posedge clk);
      #1;
      chk(in_ready == 1'b1, "R9 ready back after walk", in_ready, 1);

      // directed: linear, tiled, folded (bit 9 set), element sizes, reserved
      send(32'h8000_0000, 16'd100, 14'd7, 18'd4096, 2, 0, 33, 9, 1'b0, 0, 0, "R1");
      send(32'h0, 16'd0, 14'd0, 18'd8192, 0, 1, 127, 31, 1'b0, 0, 0, "R2");
      send(32'h0, 16'd0, 14'd0, 18'd8192, 0, 1, 128, 32, 1'b0, 0, 0, "R2");
      send(32'h0, 16'd0, 14'd0, 18'd8192, 0, 2, 0, 2, 1'b0, 0, 0, "R3");
      send(32'h200, 16'd64, 14'd0, 18'd8192, 0, 2, 0, 0, 1'b0, 0, 0, "R3");
      for (int s = 0; s <= 4; s++)
         send(32'h40, 16'd3, 14'd1, 18'd2048, s, 1, 13, 4, 1'b0, 0, 0, "R5");
      send(32'h1234, 16'd5, 14'd5, 18'd512, 1, 3, 2, 2, 1'b0, 0, 0, "R4");
      send(32'h1234, 16'd5, 14'd5, 18'd512, 6, 0, 2, 2, 1'b0, 0, 0, "R4");
      send(32'h0, 16'd0, 14'd0, 18'd256, 0, 0, 0, 0, 1'b1, 0, 0, "R8");
      send(32'h100, 16'd8, 14'd2, 18'd256, 3, 0, 7, 7, 1'b1, 4, 0, "R8");

      // random mix with backpressure
      bp_en = 1'b1;
      for (int i = 0; i < 400; i++) begin
         int md, esz;
         bit wk;
         md  = ($urandom % 8 == 0) ? 3 : int'($urandom % 3);
         esz = ($urandom % 10 == 0) ? int'(5 + $urandom % 3) : int'($urandom % 5);
         wk  = ($urandom % 5 == 0);
         send($urandom, 16'($urandom), 14'($urandom), 18'($urandom),
              esz, md, int'($urandom % 4096), int'($urandom % 4096),
              wk, int'($urandom % 5), int'($urandom % 4),
              (md == 0) ? "R1" : (md == 1) ? "R2" : "R3");
      end
      bp_en = 1'b0;
      while (expq.size() != 0) @(posedge clk);
      repeat (4) @(posedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule